// File: doc/BRIEF.md
# Normalizing Ratio Divider

This block turns two unsigned 24-bit event counts into their quotient A/B, expressed as a short floating-point pair: an 18-bit significand and a signed 6-bit power of two. It is meant for a counting front end that latches two counter banks at a slow, fixed rate and wants a ratio with more than five decimal digits of precision. It does not need a full-width integer divider for this.

An operand pair is offered on a valid/ready handshake. On acceptance the block shifts each operand left until its top bit is set, one operand per cycle, through a single shared leading-zero counter and barrel shifter. It keeps each shift count. The exponent of the result is the difference of the two shift counts. The two normalized significands then pass through a restoring divider that produces one quotient bit per cycle. A final step renormalizes the quotient so that its top bit is set.

The result is presented on a second valid/ready handshake. While the result waits for `out_ready`, it is held steady, and no new operands are taken (back-pressure reaches the input through `in_ready`). A zero divisor is reported with a flag and no divide is run. A zero dividend returns a zero result. Operands arrive at most once per millisecond, so the sequential latency of a few tens of cycles has no effect on throughput.

Top module: `ratio_div`

## Requirements
- R1: During and right after reset, `in_ready` is 1, `busy` is 0 and `out_valid` is 0.
- R2: A pair is taken only on a cycle with `in_valid` and `in_ready` both high. From the next cycle until the result is accepted, `busy` is 1 and `in_ready` is 0. Operands offered in that time have no effect on the result.
- R3: For nonzero A and B, the result satisfies q_sig = floor(A/B × 2^(17 − q_exp)). Here `q_sig` is unsigned with its binary point after bit 17, `q_exp` is two's complement, and the ratio equals q_sig × 2^(q_exp − 17) truncated to within one unit of bit 0.
- R4: Every nonzero result is normalized: bit 17 of `q_sig` is 1.
- R5: For nonzero operands, q_exp = floor(log2(A/B)), which always lies in the range −24 to +23.
- R6: When B is 0, the result has `div_by_zero` = 1, `q_sig` = 0 and `q_exp` = 0, whatever A is.
- R7: When A is 0 and B is nonzero, the result has `q_sig` = 0, `q_exp` = 0 and `div_by_zero` = 0.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `q_sig`, `q_exp` and `div_by_zero` do not change. The cycle after `out_valid` and `out_ready` are both high, `out_valid` is 0 and `in_ready` is 1.
- R9: When A or B is zero, `out_valid` rises in the cycle right after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take an operand pair |
| a | input | 24 | Dividend count A |
| b | input | 24 | Divisor count B |
| busy | output | 1 | An operation is in progress or its result is waiting to be accepted |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer accepts the result |
| q_sig | output | 18 | Quotient significand, binary point after bit 17 |
| q_exp | output | 6 | Quotient exponent, signed |
| div_by_zero | output | 1 | B was zero |

## Verification
The assertions put no constraint on `out_ready`: a consumer may hold it low for any number of cycles. They assume only that operands count when `in_valid` meets `in_ready`, and that `a` and `b` may change freely at any other time. The stimulus keeps `out_ready` low for a random 0 to 3 cycles on every result. It also drives `in_valid` with unrelated operands while the block is busy, to show these are ignored. It mixes operands of random bit lengths, so that exponents across the whole range are covered, with directed extremes: equal operands, 1 over full scale, full scale over 1, and both zero cases.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_NORM_A,
    S_NORM_B,
    S_DIV,
    S_FIX,
    S_DONE
  } rdiv_state_e;
endpackage

// File: rtl/rdiv_norm.sv
// Priority leading-zero count plus logarithmic barrel shift to the left.
module rdiv_norm #(
  parameter int W   = 24,
  parameter int LZW = $clog2(W)
) (
  input  logic [W-1:0]   x,
  output logic [W-1:0]   y,
  output logic [LZW-1:0] lz
);
  int  cnt;
  logic seen;

  always_comb begin
    cnt  = 0;
    seen = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!seen) begin
        if (x[i]) seen = 1'b1;
        else      cnt  = cnt + 1;
      end
    end
    lz = LZW'(cnt);
  end

  logic [W-1:0] stg [LZW+1];
  assign stg[0] = x;

  for (genvar k = 0; k < LZW; k++) begin : g_shift
    assign stg[k+1] = lz[k] ? (stg[k] << (1 << k)) : stg[k];
  end

  assign y = stg[LZW];
endmodule

// File: rtl/rdiv_core.sv
// Restoring divider: one trial subtraction and one quotient bit per enabled cycle.
module rdiv_core #(
  parameter int W  = 24,
  parameter int QW = 19
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          en,
  input  logic [W-1:0]  dvd,
  input  logic [W-1:0]  dvs,
  output logic [QW-1:0] quot
);
  logic [W:0]   rem;
  logic [W-1:0] dvs_q;
  logic [W+1:0] trial;
  logic         take;
  logic [W:0]   nxt;

  always_comb begin
    trial = {1'b0, rem} - {2'b00, dvs_q};
    take  = ~trial[W+1];
    nxt   = take ? trial[W:0] : rem;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      dvs_q <= '0;
      quot  <= '0;
    end else if (load) begin
      rem   <= {1'b0, dvd};
      dvs_q <= dvs;
      quot  <= '0;
    end else if (en) begin
      rem   <= nxt << 1;
      quot  <= {quot[QW-2:0], take};
    end
  end
endmodule

// File: rtl/ratio_div.sv
module ratio_div #(
  parameter int W  = 24,
  parameter int SW = 18,
  parameter int EW = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  output logic                 busy,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [SW-1:0]        q_sig,
  output logic signed [EW-1:0] q_exp,
  output logic                 div_by_zero
);
  import rdiv_pkg::*;

  localparam int LZW = $clog2(W);
  localparam int QW  = SW + 1;
  localparam int CW  = $clog2(QW);

  rdiv_state_e    state;
  logic [W-1:0]   opa, opb;
  logic [LZW-1:0] lza;
  logic [EW-1:0]  expo;
  logic [CW-1:0]  cnt;
  logic [SW-1:0]  sig_q;
  logic [EW-1:0]  exp_q;
  logic           dz_q;

  logic [W-1:0]   norm_in, norm_y;
  logic [LZW-1:0] norm_lz;
  logic [QW-1:0]  quot;

  assign norm_in = (state == S_NORM_A) ? opa : opb;

  rdiv_norm #(.W(W), .LZW(LZW)) u_norm (
    .x (norm_in),
    .y (norm_y),
    .lz(norm_lz)
  );

  rdiv_core #(.W(W), .QW(QW)) u_core (
    .clk (clk),
    .rst (rst),
    .load(state == S_NORM_B),
    .en  (state == S_DIV),
    .dvd (opa),
    .dvs (norm_y),
    .quot(quot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      opa   <= '0;
      opb   <= '0;
      lza   <= '0;
      expo  <= '0;
      cnt   <= '0;
      sig_q <= '0;
      exp_q <= '0;
      dz_q  <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (in_valid) begin
          if (b == '0) begin
            sig_q <= '0;
            exp_q <= '0;
            dz_q  <= 1'b1;
            state <= S_DONE;
          end else if (a == '0) begin
            sig_q <= '0;
            exp_q <= '0;
            dz_q  <= 1'b0;
            state <= S_DONE;
          end else begin
            opa   <= a;
            opb   <= b;
            state <= S_NORM_A;
          end
        end
        S_NORM_A: begin
          opa   <= norm_y;
          lza   <= norm_lz;
          state <= S_NORM_B;
        end
        S_NORM_B: begin
          expo  <= {{(EW-LZW){1'b0}}, norm_lz} - {{(EW-LZW){1'b0}}, lza};
          cnt   <= '0;
          state <= S_DIV;
        end
        S_DIV: begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(QW - 1)) state <= S_FIX;
        end
        S_FIX: begin
          if (quot[QW-1]) begin
            sig_q <= quot[QW-1:1];
            exp_q <= expo;
          end else begin
            sig_q <= quot[QW-2:0];
            exp_q <= expo - EW'(1);
          end
          dz_q  <= 1'b0;
          state <= S_DONE;
        end
        S_DONE: if (out_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign in_ready    = (state == S_IDLE);
  assign busy        = (state != S_IDLE);
  assign out_valid   = (state == S_DONE);
  assign q_sig       = sig_q;
  assign q_exp       = exp_q;
  assign div_by_zero = dz_q;
endmodule

// File: rtl/rdiv_chk.sv
module rdiv_chk #(
  parameter int W  = 24,
  parameter int SW = 18,
  parameter int EW = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [W-1:0]         a,
  input logic [W-1:0]         b,
  input logic                 busy,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [SW-1:0]        q_sig,
  input logic signed [EW-1:0] q_exp,
  input logic                 div_by_zero
);
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> busy && !in_ready);

  a_r4_normalized: assert property (@(posedge clk) disable iff (rst)
    out_valid && (q_sig != '0) |-> q_sig[SW-1]);

  a_r5_exp_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(q_exp) >= -W) && (int'(q_exp) <= W - 1));

  a_r6_zero_div: assert property (@(posedge clk) disable iff (rst)
    out_valid && div_by_zero |-> (q_sig == '0) && (q_exp == '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(q_sig) && $stable(q_exp)
                                && $stable(div_by_zero));

  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready |=> !out_valid && in_ready);
endmodule

bind ratio_div rdiv_chk #(.W(W), .SW(SW), .EW(EW)) u_chk (.*);

// File: tb/ratio_div_tb.sv
`timescale 1ns/1ps
module ratio_div_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        out_ready = 1'b0;
  logic [23:0] a = '0, b = '0;
  logic        in_ready, busy, out_valid, div_by_zero;
  logic [17:0] q_sig;
  logic signed [5:0] q_exp;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  ratio_div u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .a(a), .b(b), .busy(busy), .out_valid(out_valid), .out_ready(out_ready),
    .q_sig(q_sig), .q_exp(q_exp), .div_by_zero(div_by_zero)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic void model(input logic [23:0] ta, input logic [23:0] tb,
                                output longint es, output longint ee, output bit ed);
    logic [95:0] num, den, v;
    es = 0; ee = 0; ed = 0;
    if (tb == 0) begin ed = 1; return; end
    if (ta == 0) return;
    for (int e = -24; e <= 23; e++) begin
      int sh;
      sh = 17 - e;
      if (sh >= 0) begin num = 96'(ta) << sh; den = 96'(tb); end
      else begin num = 96'(ta); den = 96'(tb) << (-sh); end
      v = num / den;
      if (v >= 96'h20000 && v < 96'h40000) begin es = longint'(v); ee = e; end
    end
  endfunction

  task automatic run_op(input logic [23:0] ta, input logic [23:0] tb, input bit junk);
    longint es, ee;
    bit ed;
    int wait_n;
    logic [17:0] hs;
    logic [5:0]  he;
    model(ta, tb, es, ee, ed);
    while (!in_ready) @(negedge clk);
    a = ta; b = tb; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (ta == 0 || tb == 0)
      chk(out_valid == 1'b1, "R9 zero operand result next cycle", out_valid, 1);
    else
      chk(busy && !in_ready, "R2 busy after accept", {busy, in_ready}, 2);
    if (junk && !out_valid) begin
      a = 24'($urandom()); b = 24'($urandom()); in_valid = 1'b1;
      @(negedge clk);
      chk(!in_ready, "R2 not ready while busy", in_ready, 0);
      in_valid = 1'b0;
    end
    wait_n = 0;
    while (!out_valid && wait_n < 100) begin @(negedge clk); wait_n++; end
    chk(out_valid == 1'b1, "R3 result appears", out_valid, 1);
    if (ed) begin
      chk(div_by_zero == 1'b1, "R6 flag", div_by_zero, 1);
      chk(q_sig == 0 && q_exp == 0, "R6 zero result", {q_sig, q_exp}, 0);
    end else if (ta == 0) begin
      chk(div_by_zero == 1'b0, "R7 flag", div_by_zero, 0);
      chk(q_sig == 0 && q_exp == 0, "R7 zero result", {q_sig, q_exp}, 0);
    end else begin
      chk(div_by_zero == 1'b0, "R3 flag clear", div_by_zero, 0);
      chk(longint'(q_sig) == es, "R3 significand", q_sig, es);
      chk(longint'(int'(q_exp)) == ee, "R5 exponent", int'(q_exp), ee);
      chk(q_sig[17] == 1'b1, "R4 normalized", q_sig[17], 1);
    end
    hs = q_sig; he = q_exp;
    for (int k = 0; k < int'($urandom_range(0, 3)); k++) begin
      @(negedge clk);
      chk(out_valid && q_sig == hs && q_exp == he, "R8 hold", {out_valid, q_sig}, {1'b1, hs});
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready, "R8 release", {out_valid, in_ready}, 1);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd1357);
    repeat (3) @(negedge clk);
    chk(in_ready && !busy && !out_valid, "R1 during reset", {in_ready, busy, out_valid}, 4);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready && !busy && !out_valid, "R1 after reset", {in_ready, busy, out_valid}, 4);

    run_op(24'd12345, 24'd12345, 1'b0);
    run_op(24'd1, 24'hFFFFFF, 1'b1);
    run_op(24'hFFFFFF, 24'd1, 1'b0);
    run_op(24'd777, 24'd0, 1'b0);
    run_op(24'd0, 24'd0, 1'b0);
    run_op(24'd0, 24'd99, 1'b0);
    run_op(24'd3, 24'd2, 1'b1);
    run_op(24'd2, 24'd3, 1'b0);

    for (int n = 0; n < 80; n++) begin
      logic [23:0] ra, rb;
      ra = 24'($urandom()) >> $urandom_range(0, 23);
      rb = 24'($urandom()) >> $urandom_range(0, 23);
      if (rb == 0) rb = 24'd1;
      run_op(ra, rb, n[0]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule